// File: doc/BRIEF.md
# Synchronous Burst Static RAM with Flow-Through Reads

This block is a synthesizable single-port synchronous static RAM that presents the behaviour of a burst-capable flow-through part. Every control, address and write-data input is captured on the rising clock edge. Two address strobes can start an access. The processor-side strobe always begins a read. The controller-side strobe can also write on the edge that loads the address. After a load, a two-bit counter steps through the low two address bits. The step order is either interleaved or linear, chosen by a static order input.

Read data is combinational from the array at the current burst address, so a word is valid in the same cycle that its address was captured. The bidirectional data bus is split into a write-data input, a read-data output and a drive-enable flag. Per-lane write strobes allow partial writes. A global write input overrides them. A sleep input freezes the block and releases the bus while keeping the stored words.

Top module: `sram_burst_ft`

## Requirements
- R1: After reset the block is deselected and `dq_oe` is 0 until an access is loaded.
- R2: With `sel_n` low, `ld_cpu_n` low loads `addr` as the burst start with counter 0 and performs a read on that edge, whatever the write inputs are. `dout` shows the word at `addr` in the cycle after that edge. If both strobes are low, the processor strobe wins and nothing is written.
- R3: On an edge with no strobe, while an access is active, `wr_all_n` low writes every lane of `din` to the current burst address.
- R4: `wr_byte_n` low with `wr_all_n` high writes only the lanes whose `byte_stb_n` bit is 0. Lane i is `din[9*i+8:9*i]` with the default lane width of 9. When `wr_all_n` is low, all lanes are written regardless of the per-lane strobes.
- R5: `wr_byte_n` low with all `byte_stb_n` bits high is a read, and the stored word is unchanged.
- R6: `ld_ctl_n` low with the chip selects valid loads `addr` and applies the write inputs to `addr` on that same edge.
- R7: When `sel_n` is high, the processor strobe is ignored: no address is loaded, and an active burst keeps its address.
- R8: `sel_hi` and `sel_lo_n` are used only on strobe edges. On such an edge, `sel_hi` low or `sel_lo_n` high deselects the block (`dq_oe` 0). Changing them between strobes has no effect.
- R9: With `seq_linear` = 0, the low two address bits are the start bits XOR the counter.
- R10: With `seq_linear` = 1, the low two address bits are the start bits plus the counter, modulo 4.
- R11: On a non-strobe edge the counter increments when `burst_step_n` is low (the write address on that edge is the incremented one). It holds when `burst_step_n` is high.
- R12: While `sleep` is high, `dq_oe` is 0 and strobes, steps and writes are ignored. The burst state and array contents are kept.
- R13: `dq_oe` is 1 only when `out_en_n` is low, `sleep` is low, an access is active and the last active edge did not write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset of the control state |
| addr | input | ADDR_W | External address captured on strobe edges |
| ld_cpu_n | input | 1 | Processor-side address strobe, active low |
| ld_ctl_n | input | 1 | Controller-side address strobe, active low |
| burst_step_n | input | 1 | Advance the burst counter, active low |
| sel_n | input | 1 | Primary chip select, active low |
| sel_hi | input | 1 | Secondary chip select, active high |
| sel_lo_n | input | 1 | Secondary chip select, active low |
| wr_all_n | input | 1 | Write all lanes, active low |
| wr_byte_n | input | 1 | Enable per-lane writes, active low |
| byte_stb_n | input | LANES | Per-lane write strobes, active low |
| out_en_n | input | 1 | Output enable, active low |
| seq_linear | input | 1 | Burst order: 1 linear, 0 interleaved (static) |
| sleep | input | 1 | Sleep: release bus and ignore accesses |
| din | input | LANES*LANE_W | Write data |
| dout | output | LANES*LANE_W | Flow-through read data |
| dq_oe | output | 1 | Data bus drive enable |

## Verification
A wrong burst counter or start address shows on `dout` in the cycle right after the faulty edge, because reads are flow-through with no pipeline register. A faulty lane-write decode is hidden until that word is read back, which the bench does in the next cycle. A read-versus-write flag that is out of step shows at once on `dq_oe`. State that sleep or a blocked strobe should have frozen is exposed by the first read after the stimulus, since it would return a word from another address.

// File: rtl/sram_burst_pkg.sv
`timescale 1ns/1ps
package sram_burst_pkg;

    typedef enum logic [1:0] {
        CYC_IDLE,
        CYC_LOAD_CPU,
        CYC_LOAD_CTL,
        CYC_RUN
    } cyc_e;

    // Low two address bits for a given start value and step count
    function automatic logic [1:0] burst_lo(input logic [1:0] start,
                                            input logic [1:0] step,
                                            input logic       linear);
        return linear ? (start + step) : (start ^ step);
    endfunction

endpackage

// File: rtl/sram_wen_dec.sv
`timescale 1ns/1ps
module sram_wen_dec #(
    parameter int LANES = 2
) (
    input  logic             wr_all_n,
    input  logic             wr_byte_n,
    input  logic [LANES-1:0] byte_stb_n,
    output logic [LANES-1:0] lane_req
);
    genvar g;
    generate
        for (g = 0; g < LANES; g++) begin : g_lane
            always_comb begin
                lane_req[g] = !wr_all_n || (!wr_byte_n && !byte_stb_n[g]);
            end
        end
    endgenerate
endmodule

// File: rtl/sram_lane_mem.sv
`timescale 1ns/1ps
module sram_lane_mem #(
    parameter int AW = 8,
    parameter int W  = 9
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    localparam int DEPTH = 1 << AW;

    logic [W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/sram_ctrl.sv
`timescale 1ns/1ps
module sram_ctrl
    import sram_burst_pkg::*;
#(
    parameter int AW    = 8,
    parameter int LANES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sleep,
    input  logic             ld_cpu_n,
    input  logic             ld_ctl_n,
    input  logic             burst_step_n,
    input  logic             sel_n,
    input  logic             sel_hi,
    input  logic             sel_lo_n,
    input  logic             seq_linear,
    input  logic [AW-1:0]    addr,
    input  logic [LANES-1:0] lane_req,
    output logic [LANES-1:0] wr_en,
    output logic [AW-1:0]    wr_addr,
    output logic [AW-1:0]    rd_addr,
    output logic             act,
    output logic             rd
);
    typedef struct packed {
        logic          act;
        logic          rd;
        logic [AW-1:0] base;
        logic [1:0]    cnt;
    } st_t;

    st_t  st_d, st_q;
    cyc_e cyc;
    logic cpu_go, ctl_go, sec_ok;

    function automatic logic [AW-1:0] cur_addr(input st_t s, input logic lin);
        return {s.base[AW-1:2], burst_lo(s.base[1:0], s.cnt, lin)};
    endfunction

    always_comb begin
        cpu_go = !ld_cpu_n && !sel_n;
        ctl_go = !ld_ctl_n && !cpu_go;
        sec_ok = !sel_n && sel_hi && !sel_lo_n;

        if (sleep)              cyc = CYC_IDLE;
        else if (cpu_go)        cyc = CYC_LOAD_CPU;
        else if (ctl_go)        cyc = CYC_LOAD_CTL;
        else if (st_q.act)      cyc = CYC_RUN;
        else                    cyc = CYC_IDLE;

        st_d  = st_q;
        wr_en = '0;
        unique case (cyc)
            CYC_LOAD_CPU, CYC_LOAD_CTL: begin
                if (sec_ok) begin
                    st_d.act  = 1'b1;
                    st_d.base = addr;
                    st_d.cnt  = 2'd0;
                    wr_en     = (cyc == CYC_LOAD_CTL) ? lane_req : '0;
                    st_d.rd   = (wr_en == '0);
                end else begin
                    st_d.act = 1'b0;
                    st_d.rd  = 1'b0;
                end
            end
            CYC_RUN: begin
                if (!burst_step_n) begin
                    st_d.cnt = st_q.cnt + 2'd1;
                end
                wr_en   = lane_req;
                st_d.rd = (lane_req == '0);
            end
            default: begin
                st_d = st_q;
            end
        endcase

        wr_addr = cur_addr(st_d, seq_linear);
        rd_addr = cur_addr(st_q, seq_linear);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign act = st_q.act;
    assign rd  = st_q.rd;

    // R12
    sleep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> $stable(st_q));

    // R7
    blocked_ld_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && !ld_cpu_n && sel_n && ld_ctl_n) |=> $stable(st_q.base));

    // R2
    cpu_ld_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && !ld_cpu_n && !sel_n) |-> (wr_en == '0));

    // R11
    hold_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && ld_cpu_n && ld_ctl_n && burst_step_n) |=> $stable(st_q.cnt));

    // R11
    step_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && st_q.act && ld_cpu_n && ld_ctl_n && !burst_step_n)
        |=> (st_q.cnt == $past(st_q.cnt) + 2'd1));
endmodule

// File: rtl/sram_burst_ft.sv
`timescale 1ns/1ps
module sram_burst_ft #(
    parameter int ADDR_W = 8,
    parameter int LANES  = 2,
    parameter int LANE_W = 9
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [ADDR_W-1:0]         addr,
    input  logic                      ld_cpu_n,
    input  logic                      ld_ctl_n,
    input  logic                      burst_step_n,
    input  logic                      sel_n,
    input  logic                      sel_hi,
    input  logic                      sel_lo_n,
    input  logic                      wr_all_n,
    input  logic                      wr_byte_n,
    input  logic [LANES-1:0]          byte_stb_n,
    input  logic                      out_en_n,
    input  logic                      seq_linear,
    input  logic                      sleep,
    input  logic [LANES*LANE_W-1:0]   din,
    output logic [LANES*LANE_W-1:0]   dout,
    output logic                      dq_oe
);
    localparam int DATA_W = LANES * LANE_W;

    logic [LANES-1:0]  lane_req;
    logic [LANES-1:0]  wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [ADDR_W-1:0] rd_addr;
    logic              act;
    logic              rd;
    logic [DATA_W-1:0] rdata;

    sram_wen_dec #(.LANES(LANES)) u_dec (
        .wr_all_n   (wr_all_n),
        .wr_byte_n  (wr_byte_n),
        .byte_stb_n (byte_stb_n),
        .lane_req   (lane_req)
    );

    sram_ctrl #(.AW(ADDR_W), .LANES(LANES)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .sleep        (sleep),
        .ld_cpu_n     (ld_cpu_n),
        .ld_ctl_n     (ld_ctl_n),
        .burst_step_n (burst_step_n),
        .sel_n        (sel_n),
        .sel_hi       (sel_hi),
        .sel_lo_n     (sel_lo_n),
        .seq_linear   (seq_linear),
        .addr         (addr),
        .lane_req     (lane_req),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .rd_addr      (rd_addr),
        .act          (act),
        .rd           (rd)
    );

    genvar g;
    generate
        for (g = 0; g < LANES; g++) begin : g_mem
            sram_lane_mem #(.AW(ADDR_W), .W(LANE_W)) u_mem (
                .clk   (clk),
                .we    (wr_en[g]),
                .waddr (wr_addr),
                .wdata (din[g*LANE_W +: LANE_W]),
                .raddr (rd_addr),
                .rdata (rdata[g*LANE_W +: LANE_W])
            );
        end
    endgenerate

    assign dout  = rdata;
    assign dq_oe = !out_en_n && !sleep && act && rd;

    // R12
    sleep_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> !dq_oe);

    // R13
    no_drive_after_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && (wr_en != '0)) |=> !dq_oe);
endmodule

// File: tb/sram_burst_ft_bench.sv
`timescale 1ns/1ps
module sram_burst_ft_bench;
    localparam int AW = 8;
    localparam int DW = 18;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr;
    logic          ld_cpu_n, ld_ctl_n, burst_step_n;
    logic          sel_n, sel_hi, sel_lo_n;
    logic          wr_all_n, wr_byte_n;
    logic [1:0]    byte_stb_n;
    logic          out_en_n, seq_linear, sleep;
    logic [DW-1:0] din;
    logic [DW-1:0] dout;
    logic          dq_oe;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic          eoe;
        logic          cd;
        logic [DW-1:0] ed;
        string         tag;
    } exp_t;
    exp_t q[$];

    localparam logic [DW-1:0] D0 = 18'h12345;
    localparam logic [DW-1:0] D1 = 18'h2ABCD;
    localparam logic [DW-1:0] D2 = 18'h0F0F0;
    localparam logic [DW-1:0] D3 = 18'h35A5A;
    localparam logic [DW-1:0] WB = 18'h00155;
    localparam logic [DW-1:0] ZW = 18'h2C3C3;
    localparam logic [DW-1:0] EW = 18'h1E01E;
    localparam logic [DW-1:0] JK = 18'h3FFFF;

    always #4 clk = ~clk;

    sram_burst_ft #(.ADDR_W(AW), .LANES(2), .LANE_W(9)) u_sram_burst_ft (
        .clk(clk), .rst_n(rst_n), .addr(addr), .ld_cpu_n(ld_cpu_n),
        .ld_ctl_n(ld_ctl_n), .burst_step_n(burst_step_n), .sel_n(sel_n),
        .sel_hi(sel_hi), .sel_lo_n(sel_lo_n), .wr_all_n(wr_all_n),
        .wr_byte_n(wr_byte_n), .byte_stb_n(byte_stb_n), .out_en_n(out_en_n),
        .seq_linear(seq_linear), .sleep(sleep), .din(din), .dout(dout),
        .dq_oe(dq_oe)
    );

    task automatic idle();
        addr = '0; ld_cpu_n = 1; ld_ctl_n = 1; burst_step_n = 1;
        sel_n = 0; sel_hi = 1; sel_lo_n = 0; wr_all_n = 1; wr_byte_n = 1;
        byte_stb_n = 2'b11; out_en_n = 0; sleep = 0; din = JK;
    endtask

    // Driver: apply the current inputs for one edge and queue the expected result
    task automatic step(input logic eoe, input logic cd,
                        input logic [DW-1:0] ed, input string tag);
        exp_t e;
        @(posedge clk);
        #1;
        e.eoe = eoe; e.cd = cd; e.ed = ed; e.tag = tag;
        q.push_back(e);
        @(negedge clk);
    endtask

    // Monitor: compare queued expectations after the edge, before inputs move
    always begin
        @(posedge clk);
        #3;
        while (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (dq_oe !== e.eoe) begin
                errors++;
                $display("FAIL %s: dq_oe actual=%b expected=%b", e.tag, dq_oe, e.eoe);
            end else if (e.cd && dout !== e.ed) begin
                errors++;
                $display("FAIL %s: dout actual=%h expected=%h", e.tag, dout, e.ed);
            end
        end
    end

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL R1 watchdog: actual=hung expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        idle();
        seq_linear = 0;
        repeat (3) @(negedge clk);
        checks++;
        if (dq_oe !== 1'b0) begin
            errors++;
            $display("FAIL R1: dq_oe in reset actual=%b expected=0", dq_oe);
        end
        rst_n = 1;
        step(0, 0, '0, "R1 idle after reset");

        // R6: controller strobe writes at load; base 0x12, interleaved fill
        idle(); ld_ctl_n = 0; addr = 8'h12; wr_all_n = 0; din = D0;
        step(0, 0, '0, "R6 write on load");
        // R11/R3: each step writes the advanced address 0x13, 0x10, 0x11
        idle(); burst_step_n = 0; wr_all_n = 0; din = D1;
        step(0, 0, '0, "R3 burst write 1");
        idle(); burst_step_n = 0; wr_all_n = 0; din = D2;
        step(0, 0, '0, "R3 burst write 2");
        idle(); burst_step_n = 0; wr_all_n = 0; din = D3;
        step(0, 0, '0, "R3 burst write 3");

        // R2: processor strobe reads, write inputs ignored
        idle(); ld_cpu_n = 0; addr = 8'h12; wr_all_n = 0; din = JK;
        step(1, 1, D0, "R2 flow-through read at load");
        // R9: interleaved order from start 2 -> 3, 0, 1
        idle(); burst_step_n = 0;
        step(1, 1, D1, "R9 interleaved step 1");
        idle(); burst_step_n = 0;
        step(1, 1, D2, "R9 interleaved step 2");
        idle();
        step(1, 1, D2, "R11 hold without step");
        idle(); burst_step_n = 0;
        step(1, 1, D3, "R9 interleaved step 3");
        idle(); burst_step_n = 0;
        step(1, 1, D0, "R9 interleaved wrap");

        // R10: linear order from start 3 -> 0, 1, 2
        seq_linear = 1;
        idle(); ld_cpu_n = 0; addr = 8'h13;
        step(1, 1, D1, "R10 linear load");
        idle(); burst_step_n = 0;
        step(1, 1, D2, "R10 linear step 1");
        idle(); burst_step_n = 0;
        step(1, 1, D3, "R10 linear step 2");
        idle(); burst_step_n = 0;
        step(1, 1, D0, "R10 linear step 3");
        seq_linear = 0;

        // R5 / R4: lane writes at 0x12
        idle(); ld_cpu_n = 0; addr = 8'h12;
        step(1, 1, D0, "R2 reload");
        idle(); wr_byte_n = 0; byte_stb_n = 2'b11; din = JK;
        step(1, 1, D0, "R5 no strobe is a read");
        idle(); wr_byte_n = 0; byte_stb_n = 2'b10; din = WB;
        step(0, 0, '0, "R4 lane 0 write");
        idle();
        step(1, 1, {D0[17:9], WB[8:0]}, "R4 only lane 0 changed");
        idle(); wr_all_n = 0; wr_byte_n = 0; byte_stb_n = 2'b01; din = ZW;
        step(0, 0, '0, "R4 global write priority");
        idle();
        step(1, 1, ZW, "R4 all lanes written");

        // R2: both strobes low -> processor wins, no write
        idle(); ld_cpu_n = 0; ld_ctl_n = 0; addr = 8'h12; wr_all_n = 0; din = JK;
        step(1, 1, ZW, "R2 processor strobe priority");

        // R7: primary select high blocks processor strobe
        idle(); sel_n = 1; ld_cpu_n = 0; addr = 8'h13;
        step(1, 1, ZW, "R7 blocked strobe keeps address");

        // R8: bad secondary select on strobe edge deselects
        idle(); ld_ctl_n = 0; addr = 8'h13; sel_hi = 0;
        step(0, 0, '0, "R8 deselect on strobe");
        idle(); ld_cpu_n = 0; addr = 8'h13;
        step(1, 1, D1, "R8 reselect");
        idle(); sel_hi = 0; sel_lo_n = 1;
        step(1, 1, D1, "R8 secondaries ignored between strobes");

        // R13: output enable high releases the bus
        idle(); out_en_n = 1;
        step(0, 0, '0, "R13 out_en_n high");
        idle();
        step(1, 1, D1, "R13 out_en_n low again");

        // R12: sleep ignores a write strobe, keeps state and contents
        idle(); sleep = 1; ld_ctl_n = 0; addr = 8'h12; wr_all_n = 0; din = JK;
        step(0, 0, '0, "R12 sleep releases bus");
        idle(); sleep = 1; burst_step_n = 0;
        step(0, 0, '0, "R12 sleep ignores step");
        idle();
        step(1, 1, D1, "R12 state kept after sleep");
        idle(); ld_cpu_n = 0; addr = 8'h12;
        step(1, 1, ZW, "R12 contents kept after sleep");

        // R3: global write after a processor load
        idle(); ld_cpu_n = 0; addr = 8'h30;
        step(1, 0, '0, "R2 load 0x30");
        idle(); wr_all_n = 0; din = EW;
        step(0, 0, '0, "R3 write after load");
        idle();
        step(1, 1, EW, "R3 written word read back");

        idle();
        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule